// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Flag Generator

This block sits beside a FIFO's pointer logic and turns the FIFO's occupancy count into two active-low warning flags: one that warns the reader that few words remain and one that warns the writer that little space remains. The thresholds come from two offset registers. They start at default values and can be overwritten through a parallel load port. Each load strobe writes the next register in a fixed rotation.

Two options are captured only while master reset is held. The update-mode option picks between two disciplines:

- **Strobe-local updates:** each flag is recomputed only on cycles carrying its own side's strobe.
- **Split set/clear:** a flag is driven low by its own side's strobe and released by the opposite side's strobe.

The parity-placement option decides which bits of the 18-bit load word form the offset value. A partial reset restarts the flags from the current occupancy. It keeps the offsets and both options.

Both FIFO sides are modelled in one clock domain: `rd_stb` and `wr_stb` mark cycles with read-side and write-side activity.

Top module: `prog_flag_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the empty offset and the full offset both become 127. `ae_n` goes to 0 and `af_n` to 1. The load rotation points at the empty offset. The update mode is taken from `cfg_sync` (1 = strobe-local) and the parity placement from `cfg_ipar` (1 = interspersed).
- R2: In strobe-local mode, `ae_n` changes only after an edge with `rd_stb` high. It then becomes 0 when `level` <= empty offset, else 1. `wr_stb` has no effect on it.
- R3: In strobe-local mode, `af_n` changes only after an edge with `wr_stb` high. It then becomes 0 when DEPTH-`level` <= full offset, else 1. `rd_stb` has no effect on it.
- R4: In split mode, an edge with `rd_stb` high and `level` <= empty offset drives `ae_n` to 0. Otherwise, an edge with `wr_stb` high and `level` > empty offset drives it to 1. Otherwise it holds. Read wins when both strobes are high.
- R5: In split mode, an edge with `wr_stb` high and DEPTH-`level` <= full offset drives `af_n` to 0. Otherwise, an edge with `rd_stb` high and free space > full offset drives it to 1. Otherwise it holds.
- R6: Each edge with `ld_stb` high writes one offset and advances the rotation. The first load after a reset writes the empty offset, the next writes the full offset, and the rotation then alternates. A new value governs the flags from the following edge.
- R7: With interspersed parity, the offset is the low CW bits of {`ld_data`[17:9], `ld_data`[7:0]}. Bit 8 is dropped.
- R8: With non-interspersed parity, the offset is the low CW bits of `ld_data`[15:0]. Bit 8 counts, and bits 16 and 17 are ignored.
- R9: An edge with `prst` high (and `rst` low) sets `ae_n` and `af_n` from `level` by the R2/R3 comparisons, whatever the strobes. It returns the load rotation to the empty offset. It keeps both offsets and both options.
- R10: `cfg_sync` and `cfg_ipar` have no effect while `rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst | input | 1 | Master reset, synchronous, active high; captures options |
| prst | input | 1 | Partial reset, synchronous, active high |
| cfg_sync | input | 1 | Update mode captured during master reset (1 = strobe-local) |
| cfg_ipar | input | 1 | Parity placement captured during master reset (1 = interspersed) |
| rd_stb | input | 1 | Read-side activity in this cycle |
| wr_stb | input | 1 | Write-side activity in this cycle |
| level | input | CW | FIFO occupancy, 0 to DEPTH |
| ld_stb | input | 1 | Offset load strobe |
| ld_data | input | 18 | Parallel offset load word |
| ae_n | output | 1 | Almost-empty, active low |
| af_n | output | 1 | Almost-full, active low |

## Verification
A wrong offset register does not show until a flag is re-evaluated. It then appears as a flag flipping one level too early or too late near the threshold, which is why the checks straddle each offset by one. A wrongly latched mode shows at the first cycle where the two disciplines disagree. Examples are a write strobe raising `ae_n` in split mode, or a read strobe touching `af_n` in strobe-local mode. A misplaced parity bit shows as a shifted threshold on the first comparison after loading.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  localparam int LD_W  = 18;
  localparam int RAW_W = 17;

  // Collapse the load word to its offset bits according to parity placement.
  function automatic logic [RAW_W-1:0] offset_bits(input logic [LD_W-1:0] d,
                                                   input logic ipar);
    if (ipar) return {d[17:9], d[7:0]};
    else      return {1'b0, d[15:0]};
  endfunction
endpackage

// File: rtl/pfg_offsets.sv
module pfg_offsets
  import pfg_pkg::*;
#(
  parameter int CW     = 11,
  parameter int DEF_AE = 127,
  parameter int DEF_AF = 127
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            prst,
  input  logic            ipar,
  input  logic            ld_stb,
  input  logic [LD_W-1:0] ld_data,
  output logic [CW-1:0]   ae_off,
  output logic [CW-1:0]   af_off
);
  localparam int EXT_W = (CW > RAW_W) ? CW : RAW_W;

  logic            sel_full;
  logic [EXT_W-1:0] ext;
  logic [CW-1:0]   new_off;

  always_comb begin
    ext     = EXT_W'(offset_bits(ld_data, ipar));
    new_off = ext[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ae_off   <= CW'(DEF_AE);
      af_off   <= CW'(DEF_AF);
      sel_full <= 1'b0;
    end else if (prst) begin
      sel_full <= 1'b0;
    end else if (ld_stb) begin
      if (sel_full) af_off <= new_off;
      else          ae_off <= new_off;
      sel_full <= ~sel_full;
    end
  end
endmodule

// File: rtl/pfg_flag.sv
module pfg_flag #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic prst,
  input  logic sync_mode,
  input  logic own_ev,
  input  logic far_ev,
  input  logic hit,
  output logic flag_n
);
  always_ff @(posedge clk) begin
    if (rst)             flag_n <= RST_VAL;
    else if (prst)       flag_n <= ~hit;
    else if (sync_mode) begin
      if (own_ev)        flag_n <= ~hit;
    end else begin
      if (own_ev && hit)       flag_n <= 1'b0;
      else if (far_ev && !hit) flag_n <= 1'b1;
    end
  end
endmodule

// File: rtl/prog_flag_gen.sv
module prog_flag_gen
  import pfg_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            prst,
  input  logic            cfg_sync,
  input  logic            cfg_ipar,
  input  logic            rd_stb,
  input  logic            wr_stb,
  input  logic [CW-1:0]   level,
  input  logic            ld_stb,
  input  logic [LD_W-1:0] ld_data,
  output logic            ae_n,
  output logic            af_n
);
  localparam int DEF_OFF = 127;

  logic          mode_sync;
  logic          mode_ipar;
  logic [CW-1:0] ae_off;
  logic [CW-1:0] af_off;
  logic [CW-1:0] free_cnt;
  logic          ae_hit;
  logic          af_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_sync <= cfg_sync;
      mode_ipar <= cfg_ipar;
    end
  end

  always_comb begin
    free_cnt = CW'(DEPTH) - level;
    ae_hit   = (level <= ae_off);
    af_hit   = (free_cnt <= af_off);
  end

  pfg_offsets #(.CW(CW), .DEF_AE(DEF_OFF), .DEF_AF(DEF_OFF)) u_off (
    .clk(clk), .rst(rst), .prst(prst), .ipar(mode_ipar),
    .ld_stb(ld_stb), .ld_data(ld_data), .ae_off(ae_off), .af_off(af_off)
  );

  pfg_flag #(.RST_VAL(1'b0)) u_ae (
    .clk(clk), .rst(rst), .prst(prst), .sync_mode(mode_sync),
    .own_ev(rd_stb), .far_ev(wr_stb), .hit(ae_hit), .flag_n(ae_n)
  );

  pfg_flag #(.RST_VAL(1'b1)) u_af (
    .clk(clk), .rst(rst), .prst(prst), .sync_mode(mode_sync),
    .own_ev(wr_stb), .far_ev(rd_stb), .hit(af_hit), .flag_n(af_n)
  );
endmodule

// File: rtl/pfg_chk.sv
module pfg_chk #(
  parameter int CW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          prst,
  input logic          cfg_sync,
  input logic          rd_stb,
  input logic          wr_stb,
  input logic          ld_stb,
  input logic          ae_n,
  input logic          af_n,
  input logic          mode_sync,
  input logic          ae_hit,
  input logic          af_hit,
  input logic [CW-1:0] ae_off,
  input logic [CW-1:0] af_off
);
  AST_RESET_FLAGS: assert property (@(posedge clk) rst |=> (!ae_n && af_n)); // R1
  AST_MODE_LATCH: assert property (@(posedge clk) rst |=> (mode_sync == $past(cfg_sync))); // R1
  AST_SYNC_AE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mode_sync && !rd_stb && !prst) |=> $stable(ae_n)); // R2
  AST_SYNC_AF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mode_sync && !wr_stb && !prst) |=> $stable(af_n)); // R3
  AST_SPLIT_AE_SET: assert property (@(posedge clk) disable iff (rst)
    (!mode_sync && !prst && rd_stb && ae_hit) |=> !ae_n); // R4
  AST_SPLIT_AE_RISE: assert property (@(posedge clk) disable iff (rst)
    ($rose(ae_n) && !$past(mode_sync)) |-> ($past(wr_stb) || $past(prst))); // R4
  AST_SPLIT_AF_SET: assert property (@(posedge clk) disable iff (rst)
    (!mode_sync && !prst && wr_stb && af_hit) |=> !af_n); // R5
  AST_SPLIT_AF_RISE: assert property (@(posedge clk) disable iff (rst)
    ($rose(af_n) && !$past(mode_sync)) |-> ($past(rd_stb) || $past(prst))); // R5
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ld_stb |=> ($stable(ae_off) && $stable(af_off))); // R6
  AST_PRST_REEVAL: assert property (@(posedge clk) disable iff (rst)
    prst |=> (ae_n == !$past(ae_hit) && af_n == !$past(af_hit))); // R9
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(mode_sync)); // R10
endmodule

bind prog_flag_gen pfg_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .prst(prst), .cfg_sync(cfg_sync),
  .rd_stb(rd_stb), .wr_stb(wr_stb), .ld_stb(ld_stb),
  .ae_n(ae_n), .af_n(af_n), .mode_sync(mode_sync),
  .ae_hit(ae_hit), .af_hit(af_hit), .ae_off(ae_off), .af_off(af_off)
);

// File: tb/sim_prog_flag_gen.sv
module sim_prog_flag_gen;
  localparam int DEPTH = 1024;
  localparam int CW    = 11;
  localparam int NV    = 10;

  logic          clk = 1'b0;
  logic          rst, prst, cfg_sync, cfg_ipar, rd_stb, wr_stb, ld_stb;
  logic [CW-1:0] level;
  logic [17:0]   ld_data;
  logic          ae_n, af_n;
  int            total = 0;
  int            bad   = 0;
  bit            done  = 0;

  always #5 clk = ~clk;

  prog_flag_gen #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .prst(prst), .cfg_sync(cfg_sync), .cfg_ipar(cfg_ipar),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .level(level), .ld_stb(ld_stb),
    .ld_data(ld_data), .ae_n(ae_n), .af_n(af_n)
  );

  // {rd, wr, level[10:0], exp_ae_n, exp_af_n}, strobe-local mode, default offsets
  localparam logic [14:0] VEC [NV] = '{
    {1'b0, 1'b1, 11'd500,  1'b0, 1'b1},
    {1'b1, 1'b0, 11'd500,  1'b1, 1'b1},
    {1'b1, 1'b0, 11'd127,  1'b0, 1'b1},
    {1'b1, 1'b0, 11'd128,  1'b1, 1'b1},
    {1'b0, 1'b1, 11'd897,  1'b1, 1'b0},
    {1'b1, 1'b0, 11'd897,  1'b1, 1'b0},
    {1'b0, 1'b1, 11'd896,  1'b1, 1'b1},
    {1'b0, 1'b0, 11'd0,    1'b1, 1'b1},
    {1'b0, 1'b1, 11'd1024, 1'b1, 1'b0},
    {1'b1, 1'b0, 11'd0,    1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic eae, input logic eaf);
    total++;
    if (ae_n !== eae || af_n !== eaf) begin
      bad++;
      $display("FAIL %s: ae_n=%b af_n=%b expected ae_n=%b af_n=%b", req, ae_n, af_n, eae, eaf);
    end
  endtask

  task automatic step(input logic r, input logic w, input int lv);
    rd_stb = r; wr_stb = w; level = CW'(lv);
    @(negedge clk);
    rd_stb = 0; wr_stb = 0;
  endtask

  task automatic load(input logic [17:0] d);
    ld_stb = 1; ld_data = d;
    @(negedge clk);
    ld_stb = 0;
  endtask

  task automatic do_reset(input logic s, input logic p);
    rst = 1; cfg_sync = s; cfg_ipar = p;
    repeat (3) @(negedge clk);
    rst = 0; cfg_sync = ~s; cfg_ipar = ~p;
  endtask

  initial begin
    rst = 1; prst = 0; cfg_sync = 1; cfg_ipar = 0; rd_stb = 0; wr_stb = 0;
    ld_stb = 0; ld_data = '0; level = '0;
    @(negedge clk);

    // Strobe-local table walk
    do_reset(1'b1, 1'b0);
    chk("R1 reset flags", 1'b0, 1'b1);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][14], VEC[i][13], int'(VEC[i][12:2]));
      chk($sformatf("R2/R3 vector %0d", i), VEC[i][1], VEC[i][0]);
    end

    // Split set/clear mode
    do_reset(1'b0, 1'b0);
    step(0, 1, 500);  chk("R4 write releases ae", 1'b1, 1'b1);
    step(1, 0, 100);  chk("R4 read sets ae, R5 read releases af", 1'b0, 1'b1);
    step(0, 1, 100);  chk("R4 write below offset holds", 1'b0, 1'b1);
    step(0, 1, 1000); chk("R5 write sets af", 1'b1, 1'b0);
    step(1, 0, 1000); chk("R5 read holds af while full", 1'b1, 1'b0);
    step(1, 1, 50);   chk("R4 read precedence", 1'b0, 1'b1);
    cfg_sync = 1;
    step(0, 1, 500);  chk("R10 cfg_sync ignored", 1'b1, 1'b1);

    // Interspersed parity loading
    do_reset(1'b1, 1'b1);
    load(18'h00205);          // empty offset 261
    load(18'h00100);          // full offset 0
    step(1, 0, 261);  chk("R7 ae at 261", 1'b0, 1'b1);
    step(1, 0, 262);  chk("R7 ae above 261", 1'b1, 1'b1);
    step(0, 1, 1024); chk("R7 af full offset 0", 1'b1, 1'b0);
    step(0, 1, 1023); chk("R6 af one free", 1'b1, 1'b1);

    // Non-interspersed loading and partial reset
    do_reset(1'b1, 1'b0);
    load(18'h30205);          // empty offset 517
    load(18'h00005);          // full offset 5
    step(1, 0, 517);  chk("R8 ae at 517", 1'b0, 1'b1);
    step(1, 0, 518);  chk("R8 ae above 517", 1'b1, 1'b1);
    step(0, 1, 1019); chk("R6 af at free 5", 1'b1, 1'b0);
    prst = 1; level = 0;
    @(negedge clk);
    prst = 0;
    chk("R9 partial reset re-evaluates", 1'b0, 1'b1);
    step(0, 1, 600);  chk("R9 mode kept", 1'b0, 1'b1);
    step(1, 0, 518);  chk("R9 offset kept", 1'b1, 1'b1);
    load(18'h00003);          // rotation restarted: empty offset 3
    step(1, 0, 3);    chk("R9 rotation restart", 1'b0, 1'b1);
    step(1, 0, 4);    chk("R9 ae above 3", 1'b1, 1'b1);
    step(0, 1, 1020); chk("R9 full offset kept", 1'b1, 1'b0);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: run hung");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule